// File: doc/BRIEF.md
# PCM Slot Serializer with Frame Sync and Trailing Control Bits

This block turns parallel PCM audio words into a serial bit stream, one slot per frame, and drives the frame sync that marks each slot. It advances by one bit period on every cycle where `bclk_en` is high. It takes a new word through a valid/ready handshake at the start of every slot, and sends the word least significant bit first. Slots follow one another with no gap.

Configuration selects the slot width: 8 or 16 bits. It selects the sync style: a one-period pulse that sits on the first data bit, or a long pulse that begins one period ahead of the data. The sync polarity can be inverted. In 16-bit mode, a 2-bit count lets the last one to three slot positions carry control bits from a 3-bit configuration field instead of PCM bits. The PCM bits and the control bits then always make 16 positions. If no word is waiting when a slot starts, the block sends zeros in the PCM positions and sets a sticky underrun flag.

The sequencer has four states. `ST_IDLE` is left on the first enable after reset. `ST_LEAD` is the sync-only period used in long mode. `ST_PCM` sends the data bits. `ST_CTL` sends the control bits. The transitions are as follows:
- IDLE → LEAD (long mode) or IDLE → PCM (short mode) on the first enable.
- LEAD → PCM.
- PCM → PCM for each bit except the last.
- PCM → CTL after the last PCM bit when control bits are due.
- PCM or CTL → LEAD/PCM when a slot ends and the next one starts in the same enable cycle.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, `sd_out` is 0, `fs_out` is at its inactive level (equal to `cfg_fs_invert`), `in_ready` is 0 and `underrun` is 0. The first `bclk_en` cycle starts the first slot.
- R2: Outputs change only on clock edges where `bclk_en` is high, one bit period per enable. The first data position of a slot carries bit 0 of the accepted word.
- R3: With `cfg_wide`=0 a slot carries `in_data[7:0]` in the order bit 0 up to bit 7. With `cfg_wide`=1 it carries bits 0 up to 15−`cfg_ctl_cnt` in ascending order.
- R4: With `cfg_long_sync`=0 the frame sync is active for exactly one bit period, the one that carries bit 0.
- R5: With `cfg_long_sync`=1 the frame sync becomes active one bit period before bit 0 (`sd_out` is 0 in that lead period). Bit 0 follows in the next period.
- R6: In long mode with `cfg_wide`=0 the sync stays active for 6 bit periods, counting the lead period.
- R7: In long mode with `cfg_wide`=1 the sync stays active for 13 + `cfg_fs_len` bit periods (field value 0..3 gives 13..16), counting the lead period.
- R8: With `cfg_fs_invert`=1 the `fs_out` level is the complement of the normal one in every period.
- R9: With `cfg_wide`=1 and `cfg_ctl_cnt`=N (N=1..3), the N positions after the last PCM bit carry `cfg_ctl_bits[0]`, then `[1]`, then `[2]`. N=0 sends none.
- R10: With `cfg_wide`=0, `cfg_ctl_cnt`, `cfg_ctl_bits` and `cfg_fs_len` have no effect on the outputs.
- R11: `in_ready` is high only in the enable cycle that starts a slot, and the word is taken in that cycle. The next slot starts on the enable that follows the last bit of the current slot.
- R12: If `in_valid` is low when a slot starts, every PCM position of that slot is 0 (control bits are still sent) and `underrun` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle bit period strobe |
| in_data | input | 16 | PCM word; bits above 7 unused in 8-bit mode |
| in_valid | input | 1 | Word on `in_data` is available |
| in_ready | output | 1 | Word accepted this cycle (slot start) |
| cfg_wide | input | 1 | 0: 8-bit slot, 1: 16-bit slot |
| cfg_long_sync | input | 1 | 0: one-period sync, 1: long sync with lead period |
| cfg_fs_invert | input | 1 | Invert frame sync polarity |
| cfg_fs_len | input | 2 | Long sync length in 16-bit mode: 13 + value |
| cfg_ctl_cnt | input | 2 | Number of trailing control bits (16-bit mode) |
| cfg_ctl_bits | input | 3 | Control bit values, bit 0 sent first |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync |
| underrun | output | 1 | Sticky: a slot started with no valid word |

## Verification
Three things fall on the same enable edge: the end of one slot, the start of the next slot's sync, and the handshake. That handshake either takes the next word or, when none is offered, sets the underrun flag. The bench provokes this on every back-to-back pair of slots. It checks that `in_ready` is high in that enable cycle and only then. It checks that the first position after the old slot's last control or PCM bit already carries the new sync level and the new bit 0. In one slot with no word offered, it checks that the zero data and the set flag show up together, and that the next valid word does not clear the flag.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_PCM  = 2'd2,
        ST_CTL  = 2'd3
    } tx_state_t;

endpackage

// File: rtl/pcm_tx_fsm.sv
module pcm_tx_fsm
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W   = 16,
    parameter int NARROW_W = 8,
    parameter int IDX_W    = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_en,
    input  logic             cfg_wide,
    input  logic             cfg_long,
    input  logic [1:0]       cfg_ctl_cnt,
    output tx_state_t        nxt_state,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             frame_start
);

    localparam int LEN_W = IDX_W + 1;

    tx_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] pcm_len;
    logic [LEN_W-1:0] ctl_len;
    logic             pcm_last;
    logic             ctl_last;
    logic             at_end;

    // Slot geometry: control bits only exist in the wide slot
    always_comb begin
        ctl_len = cfg_wide ? LEN_W'(cfg_ctl_cnt) : '0;
        pcm_len = cfg_wide ? (LEN_W'(SLOT_W) - LEN_W'(cfg_ctl_cnt))
                           : LEN_W'(NARROW_W);
    end

    assign pcm_last = ({1'b0, idx_q} == (pcm_len - LEN_W'(1)));
    assign ctl_last = ({1'b0, idx_q} == (ctl_len - LEN_W'(1)));

    // Next-state logic
    always_comb begin
        nxt_state = state_q;
        nxt_idx   = idx_q;
        at_end    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                at_end = 1'b1;
            end
            ST_LEAD: begin
                nxt_state = ST_PCM;
                nxt_idx   = '0;
            end
            ST_PCM: begin
                if (pcm_last) begin
                    if (ctl_len != '0) begin
                        nxt_state = ST_CTL;
                        nxt_idx   = '0;
                    end else begin
                        at_end = 1'b1;
                    end
                end else begin
                    nxt_idx = idx_q + IDX_W'(1);
                end
            end
            ST_CTL: begin
                if (ctl_last) begin
                    at_end = 1'b1;
                end else begin
                    nxt_idx = idx_q + IDX_W'(1);
                end
            end
        endcase
        if (at_end) begin
            nxt_state = cfg_long ? ST_LEAD : ST_PCM;
            nxt_idx   = '0;
        end
    end

    assign frame_start = bclk_en && at_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else if (bclk_en) begin
            state_q <= nxt_state;
            idx_q   <= nxt_idx;
        end
    end

    assert_idle_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

    assert_lead_in_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> cfg_long);

    assert_ctl_in_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTL) |-> cfg_wide);

    assert_hold_without_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |=> ($stable(state_q) && $stable(idx_q)));

endmodule

// File: rtl/pcm_tx_fsgen.sv
module pcm_tx_fsgen #(
    parameter int NARROW_FS   = 6,
    parameter int WIDE_FS_MIN = 13,
    parameter int CNT_W       = $clog2(WIDE_FS_MIN + 4)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_en,
    input  logic       frame_start,
    input  logic       cfg_wide,
    input  logic       cfg_long,
    input  logic [1:0] cfg_fs_len,
    output logic       fs_active
);

    logic [CNT_W-1:0] pulse_len;
    logic [CNT_W-1:0] left_q;
    logic             fs_q;

    always_comb begin
        if (!cfg_long) begin
            pulse_len = CNT_W'(1);
        end else if (cfg_wide) begin
            pulse_len = CNT_W'(WIDE_FS_MIN) + CNT_W'(cfg_fs_len);
        end else begin
            pulse_len = CNT_W'(NARROW_FS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= 1'b0;
            left_q <= '0;
        end else if (bclk_en) begin
            if (frame_start) begin
                fs_q   <= 1'b1;
                left_q <= pulse_len - CNT_W'(1);
            end else if (left_q != '0) begin
                fs_q   <= 1'b1;
                left_q <= left_q - CNT_W'(1);
            end else begin
                fs_q   <= 1'b0;
            end
        end
    end

    assign fs_active = fs_q;

    assert_sync_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> fs_q);

endmodule

// File: rtl/pcm_tx_serdata.sv
module pcm_tx_serdata
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 16,
    parameter int IDX_W  = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [SLOT_W-1:0] in_data,
    input  tx_state_t         nxt_state,
    input  logic [IDX_W-1:0]  nxt_idx,
    input  logic [2:0]        cfg_ctl_bits,
    output logic              sd,
    output logic              underrun
);

    logic [SLOT_W-1:0] word_q;
    logic [SLOT_W-1:0] word_nxt;
    logic              sd_nxt;
    logic              sd_q;
    logic              urun_q;

    // A missing word becomes an all-zero word
    always_comb begin
        if (frame_start) begin
            word_nxt = in_valid ? in_data : '0;
        end else begin
            word_nxt = word_q;
        end
    end

    // Bit select for the coming bit period
    always_comb begin
        unique case (nxt_state)
            ST_PCM:  sd_nxt = word_nxt[nxt_idx];
            ST_CTL:  sd_nxt = cfg_ctl_bits[nxt_idx[1:0]];
            default: sd_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            sd_q   <= 1'b0;
            urun_q <= 1'b0;
        end else if (bclk_en) begin
            word_q <= word_nxt;
            sd_q   <= sd_nxt;
            if (frame_start && !in_valid) begin
                urun_q <= 1'b1;
            end
        end
    end

    assign sd       = sd_q;
    assign underrun = urun_q;

    assert_underrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        urun_q |=> urun_q);

    assert_starve_sets_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !in_valid) |=> urun_q);

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int NARROW_FS   = 6,
    parameter int WIDE_FS_MIN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic [SLOT_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cfg_wide,
    input  logic              cfg_long_sync,
    input  logic              cfg_fs_invert,
    input  logic [1:0]        cfg_fs_len,
    input  logic [1:0]        cfg_ctl_cnt,
    input  logic [2:0]        cfg_ctl_bits,
    output logic              sd_out,
    output logic              fs_out,
    output logic              underrun
);

    localparam int IDX_W = $clog2(SLOT_W);

    tx_state_t        nxt_state;
    logic [IDX_W-1:0] nxt_idx;
    logic             frame_start;
    logic             fs_act;

    pcm_tx_fsm #(
        .SLOT_W   (SLOT_W),
        .NARROW_W (NARROW_W),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_en     (bclk_en),
        .cfg_wide    (cfg_wide),
        .cfg_long    (cfg_long_sync),
        .cfg_ctl_cnt (cfg_ctl_cnt),
        .nxt_state   (nxt_state),
        .nxt_idx     (nxt_idx),
        .frame_start (frame_start)
    );

    pcm_tx_fsgen #(
        .NARROW_FS   (NARROW_FS),
        .WIDE_FS_MIN (WIDE_FS_MIN)
    ) u_fsgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_en     (bclk_en),
        .frame_start (frame_start),
        .cfg_wide    (cfg_wide),
        .cfg_long    (cfg_long_sync),
        .cfg_fs_len  (cfg_fs_len),
        .fs_active   (fs_act)
    );

    pcm_tx_serdata #(
        .SLOT_W (SLOT_W),
        .IDX_W  (IDX_W)
    ) u_data (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_en      (bclk_en),
        .frame_start  (frame_start),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .nxt_state    (nxt_state),
        .nxt_idx      (nxt_idx),
        .cfg_ctl_bits (cfg_ctl_bits),
        .sd           (sd_out),
        .underrun     (underrun)
    );

    assign in_ready = frame_start;
    assign fs_out   = fs_act ^ cfg_fs_invert;

    assert_short_sync_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && !cfg_long_sync && fs_act) |=> !fs_act);

    assert_quiet_between_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |=> ($stable(sd_out) && $stable(fs_act)));

    assert_lead_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_long_sync) |=> (!sd_out && fs_act));

endmodule

// File: tb/pcm_slot_tx_tb.sv
module pcm_slot_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bclk_en;
    logic [15:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic        cfg_wide, cfg_long_sync, cfg_fs_invert;
    logic [1:0]  cfg_fs_len, cfg_ctl_cnt;
    logic [2:0]  cfg_ctl_bits;
    logic        sd_out, fs_out, underrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcm_slot_tx u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_en       (bclk_en),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .cfg_wide      (cfg_wide),
        .cfg_long_sync (cfg_long_sync),
        .cfg_fs_invert (cfg_fs_invert),
        .cfg_fs_len    (cfg_fs_len),
        .cfg_ctl_cnt   (cfg_ctl_cnt),
        .cfg_ctl_bits  (cfg_ctl_bits),
        .sd_out        (sd_out),
        .fs_out        (fs_out),
        .underrun      (underrun)
    );

    // Row: wide, long, inv, fs_len[2], ctl_cnt[2], ctl_bits[3], word[16],
    //      expected sync length[5], expected PCM bit count[5]
    localparam logic [35:0] VEC [10] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 3'd0, 16'h00A5, 5'd1,  5'd8},
        {1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 3'd0, 16'h003C, 5'd6,  5'd8},
        {1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 3'd0, 16'hA5C3, 5'd1,  5'd16},
        {1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 3'd5, 16'h1234, 5'd13, 5'd13},
        {1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 3'd6, 16'hBEEF, 5'd14, 5'd14},
        {1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 3'd3, 16'h8001, 5'd15, 5'd15},
        {1'b1, 1'b1, 1'b0, 2'd3, 2'd0, 3'd7, 16'h7F0E, 5'd16, 5'd16},
        {1'b0, 1'b1, 1'b1, 2'd3, 2'd3, 3'd7, 16'h00F0, 5'd6,  5'd8},
        {1'b1, 1'b0, 1'b1, 2'd0, 2'd3, 3'd6, 16'h5555, 5'd1,  5'd13},
        {1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 3'd1, 16'hFFFF, 5'd1,  5'd15}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        bclk_en  = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(sd_out == 1'b0, "R1", "sd after reset", int'(sd_out), 0);
        check(fs_out == cfg_fs_invert, "R1", "fs after reset", int'(fs_out), int'(cfg_fs_invert));
        check(in_ready == 1'b0, "R1", "ready after reset", int'(in_ready), 0);
        check(underrun == 1'b0, "R1", "underrun after reset", int'(underrun), 0);
    endtask

    // One slot, stepped one bit period at a time; expected stream built from R2..R12
    task automatic run_frame(input logic [15:0] w, input logic v,
                             input int fslen, input int npcm);
        logic  esd [20];
        string etag [20];
        string fstag;
        int    n = 0;
        if (cfg_long_sync) begin
            esd[n] = 1'b0; etag[n] = "R5"; n++;
        end
        for (int i = 0; i < npcm; i++) begin
            esd[n]  = v ? w[i] : 1'b0;
            etag[n] = !v ? "R12" : (i == 0 ? "R2" : "R3");
            n++;
        end
        if (cfg_wide) begin
            for (int i = 0; i < int'(cfg_ctl_cnt); i++) begin
                esd[n] = cfg_ctl_bits[i]; etag[n] = "R9"; n++;
            end
        end
        if (cfg_fs_invert)      fstag = "R8";
        else if (!cfg_long_sync) fstag = "R4";
        else if (cfg_wide)      fstag = "R7";
        else                    fstag = "R6";
        if (!cfg_wide && cfg_ctl_cnt != 2'd0) fstag = "R10";

        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            if (p == 0) begin
                in_data  = w;
                in_valid = v;
            end
            bclk_en = 1'b1;
            #1;
            // R11: handshake only at slot start
            if (p == 0) check(in_ready == 1'b1, "R11", "ready at slot start", int'(in_ready), 1);
            if (p == 1) check(in_ready == 1'b0, "R11", "ready inside slot", int'(in_ready), 0);
            @(negedge clk);
            bclk_en = 1'b0;
            check(sd_out == esd[p], etag[p], $sformatf("sd pos %0d", p), int'(sd_out), int'(esd[p]));
            check(fs_out == ((p < fslen) ^ cfg_fs_invert), fstag, $sformatf("fs pos %0d", p),
                  int'(fs_out), int'((p < fslen) ^ cfg_fs_invert));
            @(negedge clk);
            // R2: nothing moves without an enable
            check(sd_out == esd[p], "R2", "sd held", int'(sd_out), int'(esd[p]));
        end
    endtask

    initial begin
        cfg_wide = 0; cfg_long_sync = 0; cfg_fs_invert = 0;
        cfg_fs_len = 0; cfg_ctl_cnt = 0; cfg_ctl_bits = 0;
        do_reset();

        // Table walk: two back-to-back slots per configuration (R11)
        for (int r = 0; r < 10; r++) begin
            cfg_wide      = VEC[r][35];
            cfg_long_sync = VEC[r][34];
            cfg_fs_invert = VEC[r][33];
            cfg_fs_len    = VEC[r][32:31];
            cfg_ctl_cnt   = VEC[r][30:29];
            cfg_ctl_bits  = VEC[r][28:26];
            do_reset();
            run_frame(VEC[r][25:10], 1'b1, int'(VEC[r][9:5]), int'(VEC[r][4:0]));
            run_frame(~VEC[r][25:10], 1'b1, int'(VEC[r][9:5]), int'(VEC[r][4:0]));
            check(underrun == 1'b0, "R12", "no underrun with valid words", int'(underrun), 0);
        end

        // Directed: starved slot in wide long mode with control bits (R12)
        cfg_wide = 1; cfg_long_sync = 1; cfg_fs_invert = 0;
        cfg_fs_len = 2'd0; cfg_ctl_cnt = 2'd2; cfg_ctl_bits = 3'b011;
        do_reset();
        run_frame(16'hC0DE, 1'b1, 13, 14);
        check(underrun == 1'b0, "R12", "flag clear before starvation", int'(underrun), 0);
        run_frame(16'hFFFF, 1'b0, 13, 14);
        check(underrun == 1'b1, "R12", "flag set after starvation", int'(underrun), 1);
        run_frame(16'h0F0F, 1'b1, 13, 14);
        check(underrun == 1'b1, "R12", "flag sticky", int'(underrun), 1);

        // Directed: reset clears sticky flag (R1)
        do_reset();

        // Directed: narrow short mode ignores control fields (R10)
        cfg_wide = 0; cfg_long_sync = 0; cfg_ctl_cnt = 2'd3; cfg_ctl_bits = 3'b111;
        do_reset();
        run_frame(16'h0081, 1'b1, 1, 8);
        run_frame(16'h0000, 1'b1, 1, 8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule